// File: doc/BRIEF.md
# Register Scoreboard with Load-Miss Run-Ahead

This block sits at the issue stage of an in-order pipeline and answers one question each cycle: may the instruction now presented by the decoder leave? It holds one pending-write flag per architectural register and a small state machine for the single memory channel. An instruction issues as soon as its own operands and destination are free and, for memory operations, the channel is free. A load whose data is late therefore holds up only the instructions that read or overwrite its target, or that want the channel. Independent ALU and multi-cycle work keeps issuing behind it.

Completion arrives on two kinds of strobe. The memory return strobe carries the register tag of the load being answered and ends the current channel access. The functional-unit writeback ports (one per result bus) carry the tag of a finished ALU or multi-cycle result. Both strobes take effect in the cycle they arrive, both for the issue decision of that cycle and for the stored flags. They are accepted whether or not issue is stalled, so long-running units drain while the front end waits. Issue is strictly in order. The block has no queue, so a stalled instruction stays at the decoder and nothing behind it can pass.

The channel state machine has three states. CH_IDLE means no access is outstanding. CH_LOAD means a load is waiting for data. CH_STORE means a store is waiting for acknowledgement. The transitions are:
- CLAIM_LD (CH_IDLE to CH_LOAD) and CLAIM_ST (CH_IDLE to CH_STORE), taken when a memory operation is granted.
- RETIRE (CH_LOAD or CH_STORE to CH_IDLE), taken on the return strobe.
- HANDOFF (CH_LOAD or CH_STORE to CH_LOAD or CH_STORE), taken when a return and a new grant fall in the same cycle.
- HOLD (stay), taken otherwise.

Top module: `scoreboard_issue`

## Requirements
- R1: After reset every register is free and the channel is in CH_IDLE, so any valid instruction, including a load, is granted with stall_reason 3'b000.
- R2: An instruction whose operands are free issues while a load is still outstanding, as long as it is not a memory operation. This covers class ALU (2'b00) and class multi-cycle (2'b11).
- R3: An instruction reading a register with a pending write is not granted and reports stall_reason 3'b001 (data dependency). It is granted once that write completes.
- R4: While an access is outstanding, a load (class 2'b01) or a store (class 2'b10) is not granted and reports stall_reason 3'b010 (channel busy). The return strobe frees the channel for the same cycle.
- R5: An instruction that writes a register whose write is still pending is not granted and reports stall_reason 3'b100 (destination busy).
- R6: Register 0 is never pending. Using it as a source or destination never causes a stall.
- R7: A writeback or return that clears a register in the same cycle as the check lets the instruction issue in that cycle. A register cleared and written by a new instruction in the same cycle ends that cycle pending.
- R8: A load's target stays pending, however many cycles pass, until a return strobe with that register's tag arrives while the channel is in CH_LOAD.
- R9: Writeback strobes on any port clear pending registers even in cycles when issue is stalled.
- R10: stall_reason is one-hot or zero, with priority data dependency over channel busy over destination busy. It is zero whenever the grant is high or no instruction is valid.
- R11: A stalled instruction changes no state: its destination does not become pending and it does not claim the channel.
- R12: A return strobe while the channel is in CH_STORE or CH_IDLE clears no register, whatever its tag. Stores (class 2'b10) never mark a destination, whatever dec_wr says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Decoder presents an instruction |
| dec_class | input | 2 | 00 ALU, 01 load, 10 store, 11 multi-cycle |
| dec_src_a | input | REG_W | First source register (0 means unused) |
| dec_src_b | input | REG_W | Second source register (0 means unused) |
| dec_dst | input | REG_W | Destination register |
| dec_wr | input | 1 | Instruction writes dec_dst |
| mem_done | input | 1 | Memory channel completion strobe |
| mem_tag | input | REG_W | Register answered by a returning load |
| wb_valid | input | NUM_WB | Functional-unit writeback strobes, one per port |
| wb_tag | input | NUM_WB*REG_W | Writeback register tags, port 0 in the low bits |
| issue_grant | output | 1 | Presented instruction issues this cycle |
| stall_reason | output | 3 | bit0 data dependency, bit1 channel busy, bit2 destination busy |

## Verification
The assertions rely on two assumptions about the surrounding pipeline. Writeback ports never name a register whose pending write belongs to an outstanding load. A return strobe comes only while an access is outstanding, and a load return carries that load's own target. The table and directed stimulus follow these rules, except for deliberate returns in CH_STORE or CH_IDLE, which R12 says must be harmless. The stimulus also never raises two strobes for the same register in one cycle. Writebacks are issued only for registers that an ALU instruction marked earlier.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        CLS_ALU   = 2'b00,
        CLS_LOAD  = 2'b01,
        CLS_STORE = 2'b10,
        CLS_MULTI = 2'b11
    } sb_class_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'b00,
        CH_LOAD  = 2'b01,
        CH_STORE = 2'b10
    } ch_state_e;

    localparam int STALL_W    = 3;
    localparam int STALL_DATA = 0;
    localparam int STALL_MEM  = 1;
    localparam int STALL_DEST = 2;

endpackage

// File: rtl/sb_busy_table.sv
module sb_busy_table #(
    parameter int NUM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] set_vec,
    input  logic [NUM_REGS-1:0] clr_vec,
    output logic [NUM_REGS-1:0] busy_q,
    output logic [NUM_REGS-1:0] busy_eff
);

    assign busy_q[0]   = 1'b0;
    assign busy_eff[0] = 1'b0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
        logic pend_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
            end else begin
                pend_q <= (pend_q & ~clr_vec[i]) | set_vec[i];
            end
        end

        assign busy_q[i]   = pend_q;
        assign busy_eff[i] = pend_q & ~clr_vec[i];

        p_set_marks_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> busy_q[i]);

        p_clear_frees_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !busy_q[i]);
    end

endmodule

// File: rtl/sb_wb_decode.sv
module sb_wb_decode #(
    parameter int NUM_REGS = 32,
    parameter int NUM_WB   = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_WB-1:0]       wb_valid,
    input  logic [NUM_WB*REG_W-1:0] wb_tag,
    input  logic                    load_return,
    input  logic [REG_W-1:0]        mem_tag,
    output logic [NUM_REGS-1:0]     clr_vec
);

    logic [NUM_REGS-1:0] port_hit [NUM_WB+1];

    for (genvar p = 0; p < NUM_WB; p++) begin : g_port
        logic [REG_W-1:0] tag;
        assign tag = wb_tag[p*REG_W +: REG_W];
        always_comb begin
            port_hit[p] = '0;
            if (wb_valid[p]) begin
                port_hit[p][tag] = 1'b1;
            end
        end
    end

    always_comb begin
        port_hit[NUM_WB] = '0;
        if (load_return) begin
            port_hit[NUM_WB][mem_tag] = 1'b1;
        end
    end

    always_comb begin
        clr_vec = '0;
        for (int p = 0; p <= NUM_WB; p++) begin
            clr_vec = clr_vec | port_hit[p];
        end
    end

endmodule

// File: rtl/sb_mem_channel.sv
module sb_mem_channel
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_done,
    input  logic claim,
    input  logic claim_is_load,
    output logic ch_free,
    output logic load_return
);

    ch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (claim) begin
                    state_d = claim_is_load ? CH_LOAD : CH_STORE;
                end
            end
            CH_LOAD, CH_STORE: begin
                if (claim) begin
                    state_d = claim_is_load ? CH_LOAD : CH_STORE;
                end else if (mem_done) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        ch_free     = 1'b1;
        load_return = 1'b0;
        unique case (state_q)
            CH_IDLE:  ch_free = 1'b1;
            CH_LOAD: begin
                ch_free     = mem_done;
                load_return = mem_done;
            end
            CH_STORE: ch_free = mem_done;
            default:  ch_free = 1'b1;
        endcase
    end

    p_claim_when_free_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (state_q == CH_IDLE || mem_done));

    p_access_holds_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE && !mem_done) |=> (state_q == $past(state_q)));

    p_store_no_return_r12 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_LOAD) |-> !load_return);

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_valid,
    input  logic [1:0]          dec_class,
    input  logic [REG_W-1:0]    dec_src_a,
    input  logic [REG_W-1:0]    dec_src_b,
    input  logic [REG_W-1:0]    dec_dst,
    input  logic                dec_wr,
    input  logic [NUM_REGS-1:0] busy_eff,
    input  logic                ch_free,
    output logic                grant,
    output logic [STALL_W-1:0]  stall_reason,
    output logic [NUM_REGS-1:0] set_vec,
    output logic                claim,
    output logic                claim_is_load
);

    sb_class_e cls;
    logic      is_mem, writes, data_hz, mem_hz, dest_hz;

    assign cls = sb_class_e'(dec_class);

    always_comb begin
        is_mem  = (cls == CLS_LOAD) || (cls == CLS_STORE);
        writes  = dec_wr && (cls != CLS_STORE) && (dec_dst != '0);
        data_hz = busy_eff[dec_src_a] || busy_eff[dec_src_b];
        mem_hz  = is_mem && !ch_free;
        dest_hz = writes && busy_eff[dec_dst];
    end

    always_comb begin
        stall_reason = '0;
        if (dec_valid) begin
            if (data_hz) begin
                stall_reason[STALL_DATA] = 1'b1;
            end else if (mem_hz) begin
                stall_reason[STALL_MEM] = 1'b1;
            end else if (dest_hz) begin
                stall_reason[STALL_DEST] = 1'b1;
            end
        end
        grant         = dec_valid && !data_hz && !mem_hz && !dest_hz;
        claim         = grant && is_mem;
        claim_is_load = (cls == CLS_LOAD);
        set_vec       = '0;
        if (grant && writes) begin
            set_vec[dec_dst] = 1'b1;
        end
    end

    p_reason_onehot_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stall_reason));

    p_grant_no_reason_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (stall_reason == '0));

    p_stall_has_reason_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !grant) |-> (stall_reason != '0));

    p_stall_no_mark_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (set_vec == '0 && !claim));

endmodule

// File: rtl/scoreboard_issue.sv
module scoreboard_issue
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_WB   = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dec_valid,
    input  logic [1:0]              dec_class,
    input  logic [REG_W-1:0]        dec_src_a,
    input  logic [REG_W-1:0]        dec_src_b,
    input  logic [REG_W-1:0]        dec_dst,
    input  logic                    dec_wr,
    input  logic                    mem_done,
    input  logic [REG_W-1:0]        mem_tag,
    input  logic [NUM_WB-1:0]       wb_valid,
    input  logic [NUM_WB*REG_W-1:0] wb_tag,
    output logic                    issue_grant,
    output logic [STALL_W-1:0]      stall_reason
);

    logic [NUM_REGS-1:0] set_vec, clr_vec, busy_q, busy_eff;
    logic                ch_free, load_return, claim, claim_is_load;

    sb_mem_channel u_chan (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_done      (mem_done),
        .claim         (claim),
        .claim_is_load (claim_is_load),
        .ch_free       (ch_free),
        .load_return   (load_return)
    );

    sb_wb_decode #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB)) u_wbdec (
        .wb_valid    (wb_valid),
        .wb_tag      (wb_tag),
        .load_return (load_return),
        .mem_tag     (mem_tag),
        .clr_vec     (clr_vec)
    );

    sb_busy_table #(.NUM_REGS(NUM_REGS)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .busy_q   (busy_q),
        .busy_eff (busy_eff)
    );

    sb_issue_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_valid     (dec_valid),
        .dec_class     (dec_class),
        .dec_src_a     (dec_src_a),
        .dec_src_b     (dec_src_b),
        .dec_dst       (dec_dst),
        .dec_wr        (dec_wr),
        .busy_eff      (busy_eff),
        .ch_free       (ch_free),
        .grant         (issue_grant),
        .stall_reason  (stall_reason),
        .set_vec       (set_vec),
        .claim         (claim),
        .claim_is_load (claim_is_load)
    );

    p_r0_never_stalls_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == CLS_ALU && dec_src_a == '0 &&
         dec_src_b == '0 && dec_dst == '0) |-> issue_grant);

    p_r0_stays_free_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q[0]);

endmodule

// File: tb/scoreboard_issue_tb_top.sv
module scoreboard_issue_tb_top;

    localparam int NUM_REGS = 32;
    localparam int NUM_WB   = 2;
    localparam int REG_W    = 5;
    localparam int NV       = 27;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    dec_valid = 1'b0;
    logic [1:0]              dec_class = 2'b00;
    logic [REG_W-1:0]        dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic                    dec_wr = 1'b0;
    logic                    mem_done = 1'b0;
    logic [REG_W-1:0]        mem_tag = '0;
    logic [NUM_WB-1:0]       wb_valid = '0;
    logic [NUM_WB*REG_W-1:0] wb_tag = '0;
    logic                    issue_grant;
    logic [2:0]              stall_reason;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    scoreboard_issue #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_valid    (dec_valid),
        .dec_class    (dec_class),
        .dec_src_a    (dec_src_a),
        .dec_src_b    (dec_src_b),
        .dec_dst      (dec_dst),
        .dec_wr       (dec_wr),
        .mem_done     (mem_done),
        .mem_tag      (mem_tag),
        .wb_valid     (wb_valid),
        .wb_tag       (wb_tag),
        .issue_grant  (issue_grant),
        .stall_reason (stall_reason)
    );

    // {valid, class, src_a, src_b, dst, wr, mem_done, mem_tag, wb0_v, wb0_tag, exp_grant, exp_reason}
    localparam logic [34:0] VEC [NV] = '{
        {1'b1,2'd0,5'd2 ,5'd3 ,5'd1 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}, // 0  R1 alu r1
        {1'b1,2'd1,5'd5 ,5'd0 ,5'd4 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}, // 1  R1 load r4
        {1'b1,2'd0,5'd2 ,5'd3 ,5'd6 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}, // 2  R2 run-ahead
        {1'b1,2'd0,5'd4 ,5'd2 ,5'd7 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b001}, // 3  R3 needs r4
        {1'b1,2'd0,5'd4 ,5'd2 ,5'd7 ,1'b1,1'b0,5'd0 ,1'b1,5'd1 ,1'b0,3'b001}, // 4  R9 wb r1 while stalled
        {1'b1,2'd0,5'd1 ,5'd0 ,5'd8 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}, // 5  R9 r1 now free
        {1'b1,2'd1,5'd2 ,5'd0 ,5'd9 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b010}, // 6  R4 second load
        {1'b1,2'd2,5'd2 ,5'd3 ,5'd0 ,1'b0,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b010}, // 7  R4 store
        {1'b1,2'd0,5'd2 ,5'd3 ,5'd6 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b100}, // 8  R5 r6 pending
        {1'b1,2'd0,5'd4 ,5'd0 ,5'd10,1'b1,1'b1,5'd4 ,1'b0,5'd0 ,1'b1,3'b000}, // 9  R7 return bypass
        {1'b1,2'd0,5'd10,5'd8 ,5'd8 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b001}, // 10 R10 data beats dest
        {1'b1,2'd1,5'd0 ,5'd0 ,5'd8 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b100}, // 11 R5 load, dest r8
        {1'b1,2'd0,5'd0 ,5'd0 ,5'd0 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}, // 12 R6 r0
        {1'b1,2'd0,5'd0 ,5'd0 ,5'd0 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}, // 13 R6 r0 again
        {1'b1,2'd2,5'd2 ,5'd3 ,5'd9 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}, // 14 R11 store, no mark r9
        {1'b1,2'd1,5'd2 ,5'd9 ,5'd11,1'b1,1'b1,5'd10,1'b0,5'd0 ,1'b1,3'b000}, // 15 R12 store done, tag r10
        {1'b1,2'd0,5'd10,5'd0 ,5'd12,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b001}, // 16 R12 r10 still pending
        {1'b1,2'd0,5'd10,5'd0 ,5'd12,1'b1,1'b0,5'd0 ,1'b1,5'd10,1'b1,3'b000}, // 17 R7 wb bypass
        {1'b0,2'd0,5'd0 ,5'd0 ,5'd0 ,1'b0,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b000}, // 18 R10 no valid
        {1'b0,2'd0,5'd11,5'd0 ,5'd0 ,1'b0,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b000}, // 19 R8 idle
        {1'b0,2'd0,5'd11,5'd0 ,5'd0 ,1'b0,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b000}, // 20 R8 idle
        {1'b1,2'd0,5'd11,5'd0 ,5'd13,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b001}, // 21 R8 load target held
        {1'b1,2'd0,5'd11,5'd0 ,5'd13,1'b1,1'b1,5'd11,1'b0,5'd0 ,1'b1,3'b000}, // 22 R8 return frees
        {1'b1,2'd0,5'd7 ,5'd9 ,5'd1 ,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}, // 23 R11 r7,r9 never marked
        {1'b0,2'd0,5'd0 ,5'd0 ,5'd0 ,1'b0,1'b1,5'd6 ,1'b0,5'd0 ,1'b0,3'b000}, // 24 R12 idle return
        {1'b1,2'd0,5'd6 ,5'd0 ,5'd14,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b0,3'b001}, // 25 R12 r6 still pending
        {1'b1,2'd3,5'd2 ,5'd3 ,5'd14,1'b1,1'b0,5'd0 ,1'b0,5'd0 ,1'b1,3'b000}  // 26 R2 multi-cycle
    };

    task automatic check(input logic eg, input logic [2:0] er, input string tag);
        n_checks++;
        if (issue_grant !== eg || stall_reason !== er) begin
            n_fails++;
            $display("FAIL %s: grant=%b reason=%b expected grant=%b reason=%b",
                     tag, issue_grant, stall_reason, eg, er);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] c, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] d, input logic w,
                         input logic md, input logic [4:0] mt,
                         input logic [1:0] wv, input logic [9:0] wt);
        dec_valid = v; dec_class = c; dec_src_a = a; dec_src_b = b;
        dec_dst = d; dec_wr = w; mem_done = md; mem_tag = mt;
        wb_valid = wv; wb_tag = wt;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 2'b00, 10'd0);
    endtask

    initial begin
        #(200000 * 10);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1: outputs idle while nothing presented in reset
        #2 check(1'b0, 3'b000, "R1 reset idle");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            @(negedge clk);
            v = VEC[i];
            drive(v[34], v[33:32], v[31:27], v[26:22], v[21:17], v[16],
                  v[15], v[14:10], {1'b0, v[9]}, {5'd0, v[8:4]});
            #2 check(v[3], v[2:0], $sformatf("vector %0d", i));
        end

        // R1: reset clears pending registers (r6, r8) and the channel
        @(negedge clk);
        drive(1'b1, 2'd1, 5'd0, 5'd0, 5'd17, 1'b1, 1'b0, 5'd0, 2'b00, 10'd0);
        #2 check(1'b1, 3'b000, "R1 load before reset");
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 2'd0, 5'd6, 5'd8, 5'd15, 1'b1, 1'b0, 5'd0, 2'b00, 10'd0);
        #2 check(1'b1, 3'b000, "R1 regs free after reset");
        @(negedge clk);
        drive(1'b1, 2'd1, 5'd0, 5'd0, 5'd16, 1'b1, 1'b0, 5'd0, 2'b00, 10'd0);
        #2 check(1'b1, 3'b000, "R1 channel idle after reset");

        // R9: writeback port 1 clears a pending register
        @(negedge clk);
        drive(1'b1, 2'd0, 5'd0, 5'd0, 5'd20, 1'b1, 1'b0, 5'd0, 2'b00, 10'd0);
        #2 check(1'b1, 3'b000, "R9 mark r20");
        @(negedge clk);
        drive(1'b1, 2'd0, 5'd20, 5'd0, 5'd21, 1'b1, 1'b0, 5'd0, 2'b10, {5'd20, 5'd0});
        #2 check(1'b1, 3'b000, "R9 port1 clears r20");

        // R7: clear and re-mark r21 in the same cycle
        @(negedge clk);
        drive(1'b1, 2'd0, 5'd0, 5'd0, 5'd21, 1'b1, 1'b0, 5'd0, 2'b01, {5'd0, 5'd21});
        #2 check(1'b1, 3'b000, "R7 clear and re-mark r21");
        @(negedge clk);
        drive(1'b1, 2'd0, 5'd21, 5'd0, 5'd22, 1'b1, 1'b0, 5'd0, 2'b00, 10'd0);
        #2 check(1'b0, 3'b001, "R7 r21 pending again");

        // R2: multi-cycle op issues while load r16 outstanding
        @(negedge clk);
        drive(1'b1, 2'd3, 5'd2, 5'd3, 5'd23, 1'b1, 1'b0, 5'd0, 2'b00, 10'd0);
        #2 check(1'b1, 3'b000, "R2 multi past load");
        // R4: store still blocked by load r16
        @(negedge clk);
        drive(1'b1, 2'd2, 5'd2, 5'd3, 5'd0, 1'b0, 1'b0, 5'd0, 2'b00, 10'd0);
        #2 check(1'b0, 3'b010, "R4 store blocked");

        @(negedge clk);
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule